// File: doc/BRIEF.md
# UART Channel Interrupt Prioritizer

This block gathers every interrupt condition of a single UART channel and holds a pending flag for each enabled source. The sources are line errors, receive data at trigger, receive idle timeout, transmit space available, modem line changes, flow-control character detection and flow-control pin edges. It encodes the most urgent pending source into a 6-bit status code and raises one interrupt output while anything is pending.

Software services the channel by reading the status code and then the register that belongs to the reported source. Each source is dropped by its own access rule. A line-status read drops line errors. A receive-holding read drops the timeout. A transmit-holding write drops transmit-ready. A modem-status read drops modem changes and both pin-edge sources. A status read drops only the source whose code it returned. The receive data-ready source is a pure level and follows the FIFO-versus-trigger comparison.

The timeout counter, the FIFOs and the serial engine are outside this block. They supply pulses and levels on the inputs.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the status code is 6'h01 and `irq` is low.
- R2: Priority from highest to lowest, with codes: line error 6'h06, receive timeout 6'h0C, receive data 6'h04, transmit ready 6'h02, modem change 6'h00, flow character 6'h10, pin edge 6'h20. With nothing pending the code is 6'h01. Only the highest pending source is reported, and lower ones stay pending.
- R3: A cycle with any bit of `lsr_err` high and `en_line` high makes the line-error source pending. A cycle with `lsr_rd` high clears it.
- R4: The receive data source is active exactly while `en_rx` and `rx_at_trig` are both high. It needs no access to clear.
- R5: A `rx_timeout` pulse with `en_rx` high makes the timeout source pending. `rhr_rd` clears it.
- R6: Transmit ready becomes pending on the cycle where (`tx_at_trig` or `tx_empty`) goes from low to high with `en_tx` high. `thr_wr` clears it. So does `isr_rd` in a cycle where the code shown is 6'h02. An `isr_rd` showing any other code leaves it pending.
- R7: Any bit of `msr_delta` with `en_modem` high makes the modem source pending. `msr_rd` clears the modem source and both pin-edge sources.
- R8: `xoff_det` or `spec_det` with `en_char` high makes the flow-character source pending. `isr_rd` while the code shown is 6'h10 clears both. A `rx_char` pulse also clears the special-character part.
- R9: A low-to-high change of `cts_in` sets the pin-edge source only when `enh_en`, `en_cts` and `auto_cts_on` are all high. A rise of `rts_out` does the same under `enh_en`, `en_rts` and `auto_rts_on`.
- R10: A source whose enable is low is not set by its condition.
- R11: When a source's set condition and its clear access fall in the same cycle, the source stays pending.
- R12: `irq` is high exactly when the status code is not 6'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isr_rd | input | 1 | Status code read strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| rhr_rd | input | 1 | Receive holding read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| en_line | input | 1 | Line-error source enable |
| en_rx | input | 1 | Receive data and timeout enable |
| en_tx | input | 1 | Transmit ready enable |
| en_modem | input | 1 | Modem change enable |
| en_char | input | 1 | Flow-character enable |
| en_cts | input | 1 | CTS edge enable |
| en_rts | input | 1 | RTS edge enable |
| enh_en | input | 1 | Enhanced-feature enable gating pin-edge sources |
| auto_cts_on | input | 1 | Automatic CTS flow control active |
| auto_rts_on | input | 1 | Automatic RTS flow control active |
| lsr_err | input | 4 | New overrun, parity, framing and break events |
| msr_delta | input | 4 | Modem line change events |
| rx_at_trig | input | 1 | RX FIFO count at or above trigger |
| rx_timeout | input | 1 | Receive idle timeout pulse |
| tx_at_trig | input | 1 | TX FIFO at or below its trigger |
| tx_empty | input | 1 | TX FIFO empty |
| xoff_det | input | 1 | Xoff character detected pulse |
| spec_det | input | 1 | Special character detected pulse |
| rx_char | input | 1 | Next character received pulse |
| cts_in | input | 1 | CTS pin level |
| rts_out | input | 1 | RTS pin level driven by the receiver |
| isr_code | output | 6 | Highest pending source code |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the agreement between `irq` and the status code. They also check that a line error always wins the code, and that each access-based clear takes effect on the next cycle when no new set competes with it. They confirm as well that a pin-edge source never appears without the enhanced enable and flow mode. Only the bench's sequences can show the queueing of lower sources behind a higher one. The same holds for the rule that a status read clears transmit-ready only when it returned that code, and for the edge detection of the transmit condition and the pins.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       isr_rd,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  input  logic       rhr_rd,
  input  logic       thr_wr,
  input  logic       en_line,
  input  logic       en_rx,
  input  logic       en_tx,
  input  logic       en_modem,
  input  logic       en_char,
  input  logic       en_cts,
  input  logic       en_rts,
  input  logic       enh_en,
  input  logic       auto_cts_on,
  input  logic       auto_rts_on,
  input  logic [3:0] lsr_err,
  input  logic [3:0] msr_delta,
  input  logic       rx_at_trig,
  input  logic       rx_timeout,
  input  logic       tx_at_trig,
  input  logic       tx_empty,
  input  logic       xoff_det,
  input  logic       spec_det,
  input  logic       rx_char,
  input  logic       cts_in,
  input  logic       rts_out,
  output logic [5:0] isr_code,
  output logic       irq
);
  localparam logic [5:0] C_NONE = 6'h01;
  localparam logic [5:0] C_LSR  = 6'h06;
  localparam logic [5:0] C_TO   = 6'h0C;
  localparam logic [5:0] C_RX   = 6'h04;
  localparam logic [5:0] C_TX   = 6'h02;
  localparam logic [5:0] C_MS   = 6'h00;
  localparam logic [5:0] C_CHR  = 6'h10;
  localparam logic [5:0] C_PIN  = 6'h20;

  logic lsr_p, to_p, tx_p, ms_p, xo_p, sp_p, cts_p, rts_p;
  logic tx_q, cts_q, rts_q;

  wire tx_cond = tx_at_trig | tx_empty;
  wire rx_lvl  = en_rx & rx_at_trig;

  wire lsr_set = en_line & |lsr_err;
  wire to_set  = en_rx & rx_timeout;
  wire tx_set  = en_tx & tx_cond & ~tx_q;
  wire ms_set  = en_modem & |msr_delta;
  wire xo_set  = en_char & xoff_det;
  wire sp_set  = en_char & spec_det;
  wire cts_set = enh_en & en_cts & auto_cts_on & cts_in & ~cts_q;
  wire rts_set = enh_en & en_rts & auto_rts_on & rts_out & ~rts_q;

  wire rd_tx  = isr_rd & (isr_code == C_TX);
  wire rd_chr = isr_rd & (isr_code == C_CHR);

  always_comb begin
    if (lsr_p)                   isr_code = C_LSR;
    else if (to_p)               isr_code = C_TO;
    else if (rx_lvl)             isr_code = C_RX;
    else if (tx_p)               isr_code = C_TX;
    else if (ms_p)               isr_code = C_MS;
    else if (xo_p | sp_p)        isr_code = C_CHR;
    else if (cts_p | rts_p)      isr_code = C_PIN;
    else                         isr_code = C_NONE;
  end

  assign irq = lsr_p | to_p | rx_lvl | tx_p | ms_p | xo_p | sp_p | cts_p | rts_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {lsr_p, to_p, tx_p, ms_p, xo_p, sp_p, cts_p, rts_p} <= '0;
      {tx_q, cts_q, rts_q} <= '0;
    end else begin
      tx_q  <= tx_cond;
      cts_q <= cts_in;
      rts_q <= rts_out;
      lsr_p <= lsr_set | (lsr_p & ~lsr_rd);
      to_p  <= to_set  | (to_p  & ~rhr_rd);
      tx_p  <= tx_set  | (tx_p  & ~(thr_wr | rd_tx));
      ms_p  <= ms_set  | (ms_p  & ~msr_rd);
      xo_p  <= xo_set  | (xo_p  & ~rd_chr);
      sp_p  <= sp_set  | (sp_p  & ~(rd_chr | rx_char));
      cts_p <= cts_set | (cts_p & ~msr_rd);
      rts_p <= rts_set | (rts_p & ~msr_rd);
    end
  end

  assert_irq_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr_code != C_NONE));

  assert_lsr_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_p |-> isr_code == C_LSR);

  assert_lsr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !lsr_set) |=> !lsr_p);

  assert_to_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !to_set) |=> !to_p);

  assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_set) |=> !tx_p);

  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ms_set && !cts_set && !rts_set) |=> !(ms_p || cts_p || rts_p));

  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_p) |-> $past(enh_en && en_cts && auto_cts_on));
endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic en_line = 1, en_rx = 1, en_tx = 1, en_modem = 1, en_char = 1;
  logic en_cts = 1, en_rts = 1, enh_en = 1, auto_cts_on = 1, auto_rts_on = 1;
  logic [3:0] lsr_err = 0, msr_delta = 0;
  logic rx_at_trig = 0, rx_timeout = 0, tx_at_trig = 0, tx_empty = 0;
  logic xoff_det = 0, spec_det = 0, rx_char = 0, cts_in = 0, rts_out = 0;
  logic [5:0] isr_code;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_prio dut_i (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_code(input logic [5:0] code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
    ->chk_ev;
    #0;
  endtask

  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (isr_code !== e || irq !== (e != 6'h01)) begin
        fails++;
        $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                 t, isr_code, irq, e, (e != 6'h01));
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    expect_code(6'h01, "R1 reset");

    lsr_err = 4'b0100; tick(); lsr_err = 0;
    expect_code(6'h06, "R3 line error set");
    rx_timeout = 1; tick(); rx_timeout = 0;
    expect_code(6'h06, "R2 line error above timeout");
    lsr_rd = 1; tick(); lsr_rd = 0;
    expect_code(6'h0C, "R3 lsr read clears, R5 timeout queued");
    rhr_rd = 1; tick(); rhr_rd = 0;
    expect_code(6'h01, "R5 rhr read clears");

    rx_at_trig = 1; #1;
    expect_code(6'h04, "R4 rx level");
    rx_at_trig = 0; #1;
    expect_code(6'h01, "R4 rx below trigger");

    tx_empty = 1; tick();
    expect_code(6'h02, "R6 tx ready set");
    rx_at_trig = 1; #1;
    expect_code(6'h04, "R2 rx above tx");
    isr_rd = 1; tick(); isr_rd = 0; rx_at_trig = 0; #1;
    expect_code(6'h02, "R6 isr read of other code keeps tx");
    isr_rd = 1; tick(); isr_rd = 0;
    expect_code(6'h01, "R6 isr read clears tx");
    tx_empty = 0; tick(); tx_at_trig = 1; tick();
    expect_code(6'h02, "R6 trigger rise sets tx");
    thr_wr = 1; tick(); thr_wr = 0;
    expect_code(6'h01, "R6 thr write clears");
    tx_at_trig = 0; tick();

    msr_delta = 4'b0001; tick(); msr_delta = 0;
    expect_code(6'h00, "R7 modem change");
    cts_in = 1; tick();
    expect_code(6'h00, "R2 modem above pin edge");
    msr_rd = 1; tick(); msr_rd = 0;
    expect_code(6'h01, "R7 msr read clears modem and cts");
    cts_in = 0; tick();

    enh_en = 0; cts_in = 1; tick(); cts_in = 0; tick();
    expect_code(6'h01, "R9 no cts edge without enhanced enable");
    enh_en = 1; auto_cts_on = 0; cts_in = 1; tick(); cts_in = 0; tick();
    expect_code(6'h01, "R9 no cts edge without auto cts");
    auto_cts_on = 1; cts_in = 1; tick();
    expect_code(6'h20, "R9 cts edge");
    msr_rd = 1; tick(); msr_rd = 0; cts_in = 0;
    expect_code(6'h01, "R7 msr read clears cts edge");
    rts_out = 1; tick();
    expect_code(6'h20, "R9 rts edge");
    msr_rd = 1; tick(); msr_rd = 0; rts_out = 0;
    expect_code(6'h01, "R7 msr read clears rts edge");

    xoff_det = 1; tick(); xoff_det = 0;
    expect_code(6'h10, "R8 xoff set");
    isr_rd = 1; tick(); isr_rd = 0;
    expect_code(6'h01, "R8 isr read clears xoff");
    spec_det = 1; tick(); spec_det = 0;
    expect_code(6'h10, "R8 special set");
    rx_char = 1; tick(); rx_char = 0;
    expect_code(6'h01, "R8 next char clears special");
    xoff_det = 1; lsr_err = 4'b0001; tick(); xoff_det = 0; lsr_err = 0;
    isr_rd = 1; tick(); isr_rd = 0;
    expect_code(6'h06, "R8 isr read of line code keeps xoff");
    lsr_rd = 1; tick(); lsr_rd = 0;
    expect_code(6'h10, "R2 xoff queued behind line error");
    isr_rd = 1; tick(); isr_rd = 0;
    expect_code(6'h01, "R8 xoff cleared");

    en_line = 0; lsr_err = 4'b1000; tick(); lsr_err = 0;
    expect_code(6'h01, "R10 disabled line source");
    en_modem = 0; msr_delta = 4'b0100; tick(); msr_delta = 0;
    expect_code(6'h01, "R10 disabled modem source");
    en_line = 1; en_modem = 1;

    lsr_err = 4'b0010; lsr_rd = 1; tick(); lsr_err = 0; lsr_rd = 0;
    expect_code(6'h06, "R11 set wins over lsr read");
    lsr_rd = 1; tick(); lsr_rd = 0;
    expect_code(6'h01, "R12 irq drops with nothing pending");

    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule